// File: doc/BRIEF.md
# Sequencer Command Register

This block is the 16-bit read/write command word that governs an instruction sequencer. Software writes it to start or halt the sequencer, to issue a system reset, to request a short offset calibration or a full calibration, and to enter or leave a low-power standby. A read returns the live state: whether the sequencer runs, whether the reset is still in progress, which calibration is pending or in flight, and the standby setting.

The sequencer reports the end of each instruction on `instr_done`. While the sequencer runs, a stop request and a calibration request both wait for that boundary. A calibration is modelled as a fixed number of clock cycles. When it ends, its command bit clears, a one-cycle completion flag fires, and a sequencer that was running before the calibration carries on. A reset stops everything and drives the pointer, FIFO and interrupt-flag clear outputs for a short fixed window. An active standby stretches that window until standby is released.

Every write loads the whole word. Bit positions matter to software: bit 0 run, bit 1 reset, bit 2 short calibration, bit 3 full calibration, bit 4 standby, and bits 15..5 are plain storage.

Top module: `seqctl_cmd_reg`

## Requirements
- R1: After `rst_n` is released, read bit 1 and the three clear outputs are 1 for exactly RESET_HOLD (default 2) cycles, then 0; `seq_run` is 0 throughout.
- R2: Writing a word with bit 0 = 1 while stopped and idle makes `seq_run` and read bit 0 equal to 1 from the next cycle.
- R3: Writing bit 0 = 0 while running keeps `seq_run` at 1 until a cycle in which `instr_done` is 1; after that edge `seq_run` is 0. `instr_done` has no effect while stopped.
- R4: Writing bit 1 = 1 stops the sequencer at once, asserts `ptr_clear`, `fifo_clear` and `irq_clear` for RESET_HOLD cycles, and cancels any pending or active calibration with no completion flag.
- R5: While standby (bit 4) is 1, the reset bit stays 1. Once standby is written 0, it clears RESET_HOLD cycles after that write.
- R6: While read bit 1 is 1, and in any write that sets bit 1, bits 0, 2 and 3 of the written word are ignored.
- R7: A short calibration (bit 2) requested while stopped starts at once. Read bit 2 is 1 for exactly SHORT_CAL_CYCLES (default 76) cycles, then clears as `short_cal_done` pulses for one cycle.
- R8: A full calibration (bit 3) requested while stopped reads 1 on bit 3 for exactly FULL_CAL_CYCLES (default 4944) cycles, then clears as `full_cal_done` pulses for one cycle.
- R9: A write with both bits 2 and 3 set runs only the full calibration; bit 2 stays 0.
- R10: A calibration requested while running stays pending (its bit reads 1, `seq_run` stays 1) until an `instr_done` cycle. At that edge it starts and `seq_run` drops to 0 for its duration.
- R11: When a calibration ends, `seq_run` returns to 1 in the same cycle if the sequencer was running when the calibration started; otherwise it stays 0.
- R12: A calibration request made while another is pending or active is ignored.
- R13: Bit 4 written to 1 drives `standby` to 1 from the next cycle; written 0, it returns to 0.
- R14: Bits 15..5 read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 16 | Command word to write |
| instr_done | input | 1 | Current instruction completes this cycle |
| rd_data | output | 16 | Command word readback with live status |
| seq_run | output | 1 | Sequencer running |
| ptr_clear | output | 1 | Reset the instruction pointer to zero |
| fifo_clear | output | 1 | Clear the conversion FIFO |
| irq_clear | output | 1 | Clear all interrupt flags |
| standby | output | 1 | Standby mode active |
| short_cal_done | output | 1 | One-cycle pulse at the end of a short calibration |
| full_cal_done | output | 1 | One-cycle pulse at the end of a full calibration |

## Verification
The assertions assume that `instr_done` is a single-cycle indication and that no input changes near the clock edge. They also assume the calibration timer is never started while busy, which the command logic itself guarantees. The stimulus drives every input on the falling edge and raises `instr_done` for exactly one cycle. Its random phase writes words whose low four bits are zero, so the sequencer stays idle while standby, the spare bits and random `instr_done` pulses vary.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;
    localparam int BIT_RUN  = 0;
    localparam int BIT_RST  = 1;
    localparam int BIT_SCAL = 2;
    localparam int BIT_FCAL = 3;
    localparam int BIT_STBY = 4;
    localparam int CMD_BITS = 5;

    typedef enum logic {
        CAL_SHORT = 1'b0,
        CAL_FULL  = 1'b1
    } cal_kind_e;
endpackage

// File: rtl/seqctl_reset_hold.sv
module seqctl_reset_hold #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic hold_i,
    output logic active_o
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } hold_st_t;

    hold_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active && !hold_i) begin
            if (st_q.cnt == LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    // R5: standby freezes the reset window
    a_r5_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active && hold_i && !set_i |=> active_o);
    // R4: a reset command always opens the window
    a_r4_set_opens: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> active_o);
endmodule

// File: rtl/seqctl_cal_timer.sv
module seqctl_cal_timer
    import seqctl_pkg::*;
#(
    parameter int SHORT_LEN = 76,
    parameter int FULL_LEN  = 4944
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  cal_kind_e kind_i,
    input  logic      abort_i,
    output logic      busy_o,
    output cal_kind_e kind_o,
    output logic      fin_o,
    output logic      short_done_o,
    output logic      full_done_o
);
    localparam int MAXL = (FULL_LEN > SHORT_LEN) ? FULL_LEN : SHORT_LEN;
    localparam int CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_LEN - 1);
    localparam logic [CW-1:0] FULL_LAST  = CW'(FULL_LEN - 1);

    typedef struct packed {
        logic          busy;
        cal_kind_e     kind;
        logic [CW-1:0] cnt;
        logic          sdone;
        logic          fdone;
    } cal_st_t;

    cal_st_t st_q, st_d;
    logic [CW-1:0] last_cnt;

    assign last_cnt = (st_q.kind == CAL_FULL) ? FULL_LAST : SHORT_LAST;
    assign fin_o    = st_q.busy && (st_q.cnt == last_cnt);

    always_comb begin
        st_d       = st_q;
        st_d.sdone = 1'b0;
        st_d.fdone = 1'b0;
        if (abort_i) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (fin_o) begin
            st_d.busy  = 1'b0;
            st_d.cnt   = '0;
            st_d.sdone = (st_q.kind == CAL_SHORT);
            st_d.fdone = (st_q.kind == CAL_FULL);
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.kind = kind_i;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, kind: CAL_SHORT, cnt: '0, sdone: 1'b0, fdone: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o       = st_q.busy;
    assign kind_o       = st_q.kind;
    assign short_done_o = st_q.sdone;
    assign full_done_o  = st_q.fdone;

    // R9: never both completion flags at once
    a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({short_done_o, full_done_o}));
    // R7: a finishing calibration raises exactly its flag next cycle
    a_r7_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o && !abort_i |=> !busy_o && (short_done_o || full_done_o));
    // R12: a running calibration keeps its kind until it ends
    a_r12_kind_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !fin_o && !abort_i |=> busy_o && $stable(kind_o));
    // R12: the command logic never starts the timer while it is busy
    a_r12_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
endmodule

// File: rtl/seqctl_cmd_reg.sv
module seqctl_cmd_reg
    import seqctl_pkg::*;
#(
    parameter int REG_W            = 16,
    parameter int RESET_HOLD       = 2,
    parameter int SHORT_CAL_CYCLES = 76,
    parameter int FULL_CAL_CYCLES  = 4944
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             instr_done,
    output logic [REG_W-1:0] rd_data,
    output logic             seq_run,
    output logic             ptr_clear,
    output logic             fifo_clear,
    output logic             irq_clear,
    output logic             standby,
    output logic             short_cal_done,
    output logic             full_cal_done
);
    localparam int SPARE_W = REG_W - CMD_BITS;

    typedef struct packed {
        logic               run;
        logic               stop_pend;
        logic               resume;
        logic               pend;
        cal_kind_e          pend_kind;
        logic               stby;
        logic [SPARE_W-1:0] spare;
    } ctl_st_t;

    ctl_st_t st_q, st_d;

    logic      rst_active;
    logic      cal_busy;
    logic      cal_fin;
    cal_kind_e cal_kind;
    logic      wr_reset;
    logic      cmd_ok;
    logic      req_any;
    cal_kind_e req_kind;
    logic      req_take;
    logic      boundary;
    logic      start_now;
    logic      start_late;
    logic      cal_start;
    cal_kind_e start_kind;

    assign wr_reset   = wr_en && wr_data[BIT_RST];
    assign cmd_ok     = wr_en && !wr_data[BIT_RST] && !rst_active;
    assign req_any    = cmd_ok && (wr_data[BIT_SCAL] || wr_data[BIT_FCAL]);
    assign req_kind   = wr_data[BIT_FCAL] ? CAL_FULL : CAL_SHORT;
    assign req_take   = req_any && !cal_busy && !st_q.pend;
    assign boundary   = st_q.run && instr_done;
    assign start_now  = req_take && !st_q.run;
    assign start_late = st_q.pend && (boundary || !st_q.run) && !wr_reset;
    assign cal_start  = start_now || start_late;
    assign start_kind = start_late ? st_q.pend_kind : req_kind;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.stby  = wr_data[BIT_STBY];
            st_d.spare = wr_data[REG_W-1:CMD_BITS];
        end
        if (wr_reset) begin
            st_d.run       = 1'b0;
            st_d.stop_pend = 1'b0;
            st_d.resume    = 1'b0;
            st_d.pend      = 1'b0;
        end else begin
            if (cmd_ok) begin
                if (wr_data[BIT_RUN]) begin
                    st_d.stop_pend = 1'b0;
                    if (cal_busy) begin
                        st_d.resume = 1'b1;
                    end else begin
                        st_d.run = 1'b1;
                    end
                end else begin
                    if (st_q.run) begin
                        st_d.stop_pend = 1'b1;
                    end
                    st_d.resume = 1'b0;
                end
            end
            if (req_take && st_q.run) begin
                st_d.pend      = 1'b1;
                st_d.pend_kind = req_kind;
            end
            if (boundary && st_d.stop_pend) begin
                st_d.run       = 1'b0;
                st_d.stop_pend = 1'b0;
            end
            if (cal_start) begin
                st_d.resume    = st_d.resume || st_d.run;
                st_d.run       = 1'b0;
                st_d.stop_pend = 1'b0;
                st_d.pend      = 1'b0;
            end
            if (cal_fin) begin
                st_d.run    = st_d.resume;
                st_d.resume = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, stop_pend: 1'b0, resume: 1'b0, pend: 1'b0,
                      pend_kind: CAL_SHORT, stby: 1'b0, spare: '0};
        end else begin
            st_q <= st_d;
        end
    end

    seqctl_reset_hold #(
        .HOLD(RESET_HOLD)
    ) u_reset_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (wr_reset),
        .hold_i  (st_q.stby),
        .active_o(rst_active)
    );

    seqctl_cal_timer #(
        .SHORT_LEN(SHORT_CAL_CYCLES),
        .FULL_LEN (FULL_CAL_CYCLES)
    ) u_cal_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (cal_start),
        .kind_i      (start_kind),
        .abort_i     (wr_reset),
        .busy_o      (cal_busy),
        .kind_o      (cal_kind),
        .fin_o       (cal_fin),
        .short_done_o(short_cal_done),
        .full_done_o (full_cal_done)
    );

    logic scal_rd, fcal_rd;
    assign scal_rd = (cal_busy && cal_kind == CAL_SHORT) || (st_q.pend && st_q.pend_kind == CAL_SHORT);
    assign fcal_rd = (cal_busy && cal_kind == CAL_FULL)  || (st_q.pend && st_q.pend_kind == CAL_FULL);

    assign rd_data    = {st_q.spare, st_q.stby, fcal_rd, scal_rd, rst_active, st_q.run};
    assign seq_run    = st_q.run;
    assign standby    = st_q.stby;
    assign ptr_clear  = rst_active;
    assign fifo_clear = rst_active;
    assign irq_clear  = rst_active;

    // R4: the sequencer never runs during a reset window
    a_r4_no_run_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |-> !seq_run);
    // R10: the sequencer is paused during any calibration
    a_r10_paused_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> !seq_run);
    // R3: without an instruction boundary or reset, a running sequencer keeps running
    a_r3_run_until_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        seq_run && !instr_done && !wr_reset |=> seq_run);
    // R12: at most one calibration is pending or active
    a_r12_one_cal: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_busy && st_q.pend));
endmodule

// File: tb/seqctl_cmd_reg_bench.sv
module seqctl_cmd_reg_bench;
    localparam int SHORT_N = 76;
    localparam int FULL_N  = 4944;
    localparam int HOLD_N  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        instr_done = 1'b0;
    logic [15:0] rd_data;
    logic        seq_run, ptr_clear, fifo_clear, irq_clear, standby;
    logic        short_cal_done, full_cal_done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    seqctl_cmd_reg #(
        .REG_W(16), .RESET_HOLD(HOLD_N),
        .SHORT_CAL_CYCLES(SHORT_N), .FULL_CAL_CYCLES(FULL_N)
    ) u_seqctl_cmd_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .instr_done(instr_done), .rd_data(rd_data), .seq_run(seq_run),
        .ptr_clear(ptr_clear), .fifo_clear(fifo_clear), .irq_clear(irq_clear),
        .standby(standby), .short_cal_done(short_cal_done), .full_cal_done(full_cal_done)
    );

    function automatic logic [15:0] idle_readback(input logic [15:0] v);
        return {v[15:4], 4'b0000};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_done;
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seen;
        void'($urandom(32'd1234));
        tick(3);
        rst_n = 1'b1;
        // R1: power-up reset window
        tick(1);
        chk("R1 rst bit after 1 cycle", rd_data[1], 1);
        chk("R1 fifo_clear after 1 cycle", fifo_clear, 1);
        chk("R1 run low", seq_run, 0);
        tick(1);
        chk("R1 rst bit after 2 cycles", rd_data[1], 0);
        chk("R1 ptr_clear released", ptr_clear, 0);

        // R2: start
        wr(16'h0001);
        chk("R2 run", seq_run, 1);
        chk("R2 read bit0", rd_data[0], 1);

        // R3: deferred stop
        wr(16'h0000);
        chk("R3 still running after stop write", seq_run, 1);
        tick(3);
        chk("R3 still running without boundary", seq_run, 1);
        pulse_done();
        chk("R3 stopped at boundary", seq_run, 0);

        // R4 / R6: reset, writes ignored during it
        wr(16'h0001);
        wr(16'h0002);
        chk("R4 run cleared", seq_run, 0);
        chk("R4 irq_clear", irq_clear, 1);
        wr(16'h000D);
        chk("R6 start ignored in reset", seq_run, 0);
        chk("R6 cal ignored in reset", rd_data[3:2], 0);
        chk("R4 rst still 1 at hold", rd_data[1], 1);
        tick(1);
        chk("R4 rst cleared after hold", rd_data[1], 0);
        chk("R6 nothing started", {seq_run, rd_data[3:2]}, 0);

        // R5 / R13: standby holds reset
        wr(16'h0012);
        chk("R13 standby set", standby, 1);
        tick(5);
        chk("R5 rst held by standby", rd_data[1], 1);
        wr(16'h0000);
        chk("R13 standby cleared", standby, 0);
        chk("R5 rst still 1 one cycle after", rd_data[1], 1);
        tick(1);
        chk("R5 rst still 1 two cycles after", rd_data[1], 1);
        tick(1);
        chk("R5 rst released", rd_data[1], 0);

        // R7: short calibration while stopped
        wr(16'h0004);
        chk("R7 bit2 set", rd_data[2], 1);
        tick(SHORT_N - 1);
        chk("R7 bit2 at last cycle", rd_data[2], 1);
        chk("R7 no early flag", short_cal_done, 0);
        tick(1);
        chk("R7 bit2 cleared", rd_data[2], 0);
        chk("R7 flag pulse", short_cal_done, 1);
        chk("R11 stays stopped", seq_run, 0);
        tick(1);
        chk("R7 flag one cycle", short_cal_done, 0);

        // R8 / R9: both bits -> full only
        wr(16'h000C);
        chk("R9 bit2 stays 0", rd_data[2], 0);
        chk("R8 bit3 set", rd_data[3], 1);
        tick(FULL_N - 1);
        chk("R8 bit3 at last cycle", rd_data[3], 1);
        tick(1);
        chk("R8 bit3 cleared", rd_data[3], 0);
        chk("R8 full flag", full_cal_done, 1);
        chk("R9 no short flag", short_cal_done, 0);

        // R10 / R11: calibration while running
        wr(16'h0001);
        wr(16'h0005);
        chk("R10 pending bit2", rd_data[2], 1);
        chk("R10 still running", seq_run, 1);
        tick(4);
        chk("R10 waits for boundary", seq_run, 1);
        pulse_done();
        chk("R10 paused at boundary", seq_run, 0);
        tick(SHORT_N - 1);
        chk("R10 paused during cal", seq_run, 0);
        tick(1);
        chk("R11 resumed", seq_run, 1);
        chk("R11 flag", short_cal_done, 1);
        wr(16'h0000);
        pulse_done();

        // R12: second request ignored
        wr(16'h0004);
        wr(16'h0008);
        chk("R12 full ignored while busy", rd_data[3], 0);
        tick(SHORT_N - 2);
        chk("R12 short still busy", rd_data[2], 1);
        tick(1);
        chk("R12 short done", short_cal_done, 1);
        chk("R12 no full queued", rd_data[3], 0);

        // R4: reset aborts calibration with no flag
        wr(16'h0008);
        tick(10);
        wr(16'h0002);
        chk("R4 cal cancelled", rd_data[3], 0);
        seen = 0;
        for (int i = 0; i < FULL_N + 10; i++) begin
            if (full_cal_done) seen++;
            tick(1);
        end
        chk("R4 no flag after abort", seen, 0);

        // R13 / R14 / R3: random idle writes
        for (int i = 0; i < 40; i++) begin
            logic [15:0] v;
            v = 16'($urandom) & 16'hFFF0;
            instr_done = 1'($urandom);
            wr(v);
            instr_done = 1'b0;
            chk("R14 readback", rd_data, idle_readback(v));
            chk("R13 standby follows bit4", standby, v[4]);
            chk("R3 done ignored when stopped", seq_run, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule